// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block sits between a clocked host and an asynchronous static RAM of 16,384 words by 4 bits. The host offers one word at a time with a request/ready handshake, an address, write data and a write flag. The controller turns that request into a sequence of chip-select and write-enable levels on the memory pins. Each level is held for a whole number of clock cycles, and that number is derived from nanosecond timing parameters. Read results come back on a data output, together with a one-cycle valid pulse.

All memory-side outputs come straight from flops. Their values are decoded from the next sequencer state, so the strobes cannot glitch. The address register loads only when a request is accepted, and at that moment both strobes are high. For a write, write enable falls one cycle before chip select, so the memory never turns on its output drivers. The controller's own data drive is on only while both strobes are low. It switches off on the same clock edge that raises them.

The timing counts are `ceil(ns / CLK_NS)`, each at least 1. With a 10 ns clock, the write overlap is 2 cycles: the largest of the pulse-width, data-setup and write-cycle counts. Chip select is low for 3 cycles on a read: the larger of the access-time and read-cycle counts.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, and in every cycle where `rdy_o` is 1, the memory pins rest with `mem_cs_n_o`=1, `mem_we_n_o`=1 and `mem_oe_o`=0, and `rvalid_o` is 0. `rdy_o` is 1 only in the idle state.
- R2: A request is taken on a clock edge where `req_i` and `rdy_o` are both 1. From the next cycle, `rdy_o` stays 0 until the transaction ends. Changes on `addr_i`, `wdata_i` and `we_i` while `rdy_o` is 0 have no effect on the pins or on the stored data.
- R3: `mem_addr_o` changes only while `mem_cs_n_o` is 1. It equals the accepted address from the cycle after acceptance until the next acceptance.
- R4: For a write (`we_i`=1), `mem_we_n_o` falls while `mem_cs_n_o` is still 1, and chip select falls exactly one cycle later. Write enable never falls while chip select is already low.
- R5: For a write, both strobes are low together for exactly PULSE cycles. PULSE = max(ceil(T_WP/CLK), ceil(T_DW/CLK), ceil(T_WC/CLK)), which is 2 for the defaults. `mem_dout_o` carries the accepted write data, and a later read of that address returns it.
- R6: `mem_oe_o` is 1 only in cycles where both strobes are low. It turns on only after write enable has been low for a cycle, and it is 0 in the cycle where the strobes rise. It is never 1 while the memory is selected for reading.
- R7: For a read (`we_i`=0), `mem_we_n_o` stays 1 and `mem_cs_n_o` is low for exactly RD cycles. RD = max(ceil(T_AA/CLK), ceil(T_RC/CLK)), which is 3 for the defaults. `mem_din_i` is sampled at the end of the last of those cycles. `rdata_o` shows the sample while `rvalid_o` pulses for exactly one cycle. Writes never produce a `rvalid_o` pulse.
- R8: With the defaults, `rdy_o` is 0 for 5 cycles after each acceptance (write: 3+PULSE, read: 2+RD). A request held high is taken in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 14 | Host word address |
| wdata_i | input | 4 | Host write data |
| rdy_o | output | 1 | Controller idle, request may be taken |
| rvalid_o | output | 1 | One-cycle read-data-valid pulse |
| rdata_o | output | 4 | Read data |
| mem_addr_o | output | 14 | Memory address |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_dout_o | output | 4 | Data toward the memory |
| mem_oe_o | output | 1 | Enable for the controller's data drive |
| mem_din_i | input | 4 | Data from the memory |

## Verification
Two things can land on one clock edge: the controller withdrawing its data drive, and the strobes releasing at the end of a write. A held request can then start the next transaction in the first idle cycle. The bench provokes this by keeping `req_i` high across a write followed at once by a read of the same address. A behavioural memory model judges the result. It counts any cycle where both sides drive the bus, any address movement under a low strobe and any overlap shorter or longer than expected. The bench also checks that the read returns the word just written, in the expected cycle. The model gives inverted data until the access time has passed, so a controller that samples too early returns the wrong word.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_WARM   = 3'd2,
    ST_WPULSE = 3'd3,
    ST_RACC   = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_e;

  // ceiling division of a time in ns by the clock period, never below 1
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int PULSE_CYC = 2,
  parameter int RD_CYC    = 3,
  parameter int CNT_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_sel_i,
  input  logic             last_i,
  output seq_state_e       state_q_o,
  output seq_state_e       state_d_o,
  output logic             accept_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             sample_o
);

  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d    = state_q;
    accept_o   = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    sample_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (wr_sel_i) begin
          state_d = ST_WARM;
        end else begin
          state_d    = ST_RACC;
          load_o     = 1'b1;
          load_val_o = RD_LD;
        end
      end
      ST_WARM: begin
        state_d    = ST_WPULSE;
        load_o     = 1'b1;
        load_val_o = PULSE_LD;
      end
      ST_WPULSE: begin
        if (last_i) state_d = ST_DONE;
      end
      ST_RACC: begin
        if (last_i) begin
          sample_o = 1'b1;
          state_d  = ST_DONE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

endmodule

// File: rtl/sram_io_path.sv
module sram_io_path
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              sample_i,
  input  seq_state_e        state_d_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_din_i,
  output logic              wr_sel_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dout_o,
  output logic              mem_cs_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic              cs_n_q, cs_n_d;
  logic              we_n_q, we_n_d;
  logic              oe_q, oe_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  // pin levels decoded from the next state, then registered
  always_comb begin
    cs_n_d = !((state_d_i == ST_WPULSE) || (state_d_i == ST_RACC));
    we_n_d = !((state_d_i == ST_WARM) || (state_d_i == ST_WPULSE));
    oe_d   = (state_d_i == ST_WPULSE);
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      wr_q    <= we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      cs_n_q <= cs_n_d;
      we_n_q <= we_n_d;
      oe_q   <= oe_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (sample_i) begin
      rdata_q <= mem_din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= sample_i;
    end
  end

  assign wr_sel_o   = wr_q;
  assign mem_addr_o = addr_q;
  assign mem_dout_o = wdata_q;
  assign mem_cs_n_o = cs_n_q;
  assign mem_we_n_o = we_n_q;
  assign mem_oe_o   = oe_q;
  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 4,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 20,
  parameter int T_DW_NS = 13,
  parameter int T_WC_NS = 20,
  parameter int T_AA_NS = 25,
  parameter int T_RC_NS = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rdy_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dout_o,
  output logic              mem_oe_o,
  input  logic [DATA_W-1:0] mem_din_i
);

  localparam int PULSE_CYC = max_of(max_of(ns_to_cyc(T_WP_NS, CLK_NS),
                                           ns_to_cyc(T_DW_NS, CLK_NS)),
                                    ns_to_cyc(T_WC_NS, CLK_NS));
  localparam int RD_CYC    = max_of(ns_to_cyc(T_AA_NS, CLK_NS),
                                    ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int CNT_W     = $clog2(max_of(PULSE_CYC, RD_CYC) + 1);

  seq_state_e       state_q;
  seq_state_e       state_d;
  logic             accept;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             sample;
  logic             last;
  logic             wr_sel;

  sram_seq_fsm #(
    .PULSE_CYC (PULSE_CYC),
    .RD_CYC    (RD_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .wr_sel_i   (wr_sel),
    .last_i     (last),
    .state_q_o  (state_q),
    .state_d_o  (state_d),
    .accept_o   (accept),
    .load_o     (load),
    .load_val_o (load_val),
    .sample_o   (sample)
  );

  sram_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  sram_io_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_io (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .sample_i   (sample),
    .state_d_i  (state_d),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_din_i  (mem_din_i),
    .wr_sel_o   (wr_sel),
    .mem_addr_o (mem_addr_o),
    .mem_dout_o (mem_dout_o),
    .mem_cs_n_o (mem_cs_n_o),
    .mem_we_n_o (mem_we_n_o),
    .mem_oe_o   (mem_oe_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  assign rdy_o = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W    = 14,
  parameter int PULSE_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              rdy_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_n_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_o
);

  logic [7:0] ov_cnt;

  // consecutive cycles with both strobes low, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_cnt <= '0;
    end else if (!mem_cs_n_o && !mem_we_n_o) begin
      if (ov_cnt != 8'hFF) ov_cnt <= ov_cnt + 8'd1;
    end else begin
      ov_cnt <= '0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (mem_cs_n_o && mem_we_n_o && !mem_oe_o && !rvalid_o)); // R1

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && req_i) |=> !rdy_o); // R2

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o)); // R3

  AST_WE_LEADS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> mem_cs_n_o); // R4

  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_cs_n_o) && $past(!mem_we_n_o)) |-> (ov_cnt == 8'(PULSE_CYC))); // R5

  AST_DRIVE_IN_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_oe_o |-> (!mem_cs_n_o && !mem_we_n_o)); // R6

  AST_DRIVE_AFTER_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_o) |-> $past(!mem_we_n_o)); // R6

  AST_RVALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R7

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .rdy_o      (rdy_o),
  .rvalid_o   (rvalid_o),
  .mem_addr_o (mem_addr_o),
  .mem_cs_n_o (mem_cs_n_o),
  .mem_we_n_o (mem_we_n_o),
  .mem_oe_o   (mem_oe_o)
);

// File: tb/tb_sram_strobe_ctrl.sv
module tb_sram_strobe_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_PULSE  = 2;
  localparam int EXP_RD     = 3;
  localparam int EXP_BUSY   = 5;
  localparam int NVEC       = 12;

  // vector: {write, addr[13:0], wdata[3:0], expected read data[3:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 14'h0000, 4'h3, 4'h0},
    {1'b1, 14'h3FFF, 4'hC, 4'h0},
    {1'b1, 14'h1555, 4'hA, 4'h0},
    {1'b1, 14'h2AAA, 4'h5, 4'h0},
    {1'b0, 14'h0000, 4'h0, 4'h3},
    {1'b0, 14'h3FFF, 4'h0, 4'hC},
    {1'b0, 14'h1555, 4'h0, 4'hA},
    {1'b0, 14'h2AAA, 4'h0, 4'h5},
    {1'b1, 14'h1555, 4'h6, 4'h0},
    {1'b0, 14'h1555, 4'h0, 4'h6},
    {1'b0, 14'h0001, 4'h0, 4'h0},
    {1'b0, 14'h2AAA, 4'h0, 4'h5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [13:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        rdy, rvalid;
  logic [3:0]  rdata;
  logic [13:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe;
  logic [3:0]  mem_dout, mem_din;

  int n_tests = 0;
  int n_fail  = 0;
  int n_writes = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_strobe_ctrl dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdy_o      (rdy),
    .rvalid_o   (rvalid),
    .rdata_o    (rdata),
    .mem_addr_o (mem_addr),
    .mem_cs_n_o (mem_cs_n),
    .mem_we_n_o (mem_we_n),
    .mem_dout_o (mem_dout),
    .mem_oe_o   (mem_oe),
    .mem_din_i  (mem_din)
  );

  // ---------------- behavioural memory model ----------------
  logic [3:0]  mem_model [int];
  logic [3:0]  rd_word = '0;
  int          cs_low_cnt = 0;
  int          addr_viol = 0, conflict = 0, bad_pulse = 0, nodrive = 0;
  int          lead_viol = 0, arm_cnt = 0;
  logic        prev_cs_low = 1'b0, prev_we_low = 1'b0;
  logic [13:0] prev_addr = '0;
  int          ov_len = 0;
  logic        pend = 1'b0;
  logic [13:0] waddr = '0;
  logic [3:0]  wdat = '0;

  always @(posedge clk) cs_low_cnt <= mem_cs_n ? 0 : cs_low_cnt + 1;

  // inverted data until the access time has elapsed
  assign mem_din = (cs_low_cnt >= EXP_RD - 1) ? rd_word : ~rd_word;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_cs_n && mem_we_n && mem_oe) conflict++;
      if (mem_oe && !(!mem_cs_n && !mem_we_n)) nodrive++;
      if (!mem_cs_n && !mem_we_n && !mem_oe) nodrive++;
      if (!mem_cs_n && prev_cs_low && mem_addr != prev_addr) addr_viol++;
      if (!mem_cs_n && !prev_cs_low && !mem_we_n && !prev_we_low) lead_viol++;
      if (!mem_we_n && !prev_we_low && prev_cs_low) lead_viol++;
      if (!mem_we_n && mem_cs_n && !prev_we_low) arm_cnt++;
      if (!mem_cs_n && !mem_we_n) begin
        ov_len++;
        pend  = 1'b1;
        waddr = mem_addr;
        wdat  = mem_dout;
      end else if (pend) begin
        mem_model[int'(waddr)] = wdat;
        if (ov_len != EXP_PULSE) bad_pulse++;
        pend   = 1'b0;
        ov_len = 0;
      end
      prev_cs_low = !mem_cs_n;
      prev_we_low = !mem_we_n;
      prev_addr   = mem_addr;
      rd_word = mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 4'h0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic do_txn(input logic w, input logic [13:0] a, input logic [3:0] d,
                        output logic [3:0] got, output int busy, output int nval);
    @(negedge clk);
    while (!rdy) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    if (w) n_writes++;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    busy = 0; nval = 0; got = '0;
    while (!rdy && busy < 50) begin
      busy++;
      if (rvalid) begin
        nval++;
        got = rdata;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] got;
    int busy, nval;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rdy == 1'b1,      "R1 rdy in reset",  int'(rdy), 1);
    check(mem_cs_n == 1'b1, "R1 cs_n in reset", int'(mem_cs_n), 1);
    check(mem_we_n == 1'b1, "R1 we_n in reset", int'(mem_we_n), 1);
    check(mem_oe == 1'b0,   "R1 oe in reset",   int'(mem_oe), 0);
    check(rvalid == 1'b0,   "R1 rvalid in reset", int'(rvalid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rdy && mem_cs_n && mem_we_n && !mem_oe, "R1 idle pins after reset",
          {rdy, mem_cs_n, mem_we_n, mem_oe}, 4'b1110);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      do_txn(VEC[i][22], VEC[i][21:8], VEC[i][7:4], got, busy, nval);
      check(busy == EXP_BUSY, "R8 busy length", busy, EXP_BUSY);
      if (VEC[i][22]) begin
        check(nval == 0, "R7 no rvalid on write", nval, 0);
      end else begin
        check(nval == 1, "R7 one rvalid per read", nval, 1);
        check(got == VEC[i][3:0], "R7 R5 read data", int'(got), int'(VEC[i][3:0]));
      end
    end

    // R2 R3: inputs changed while busy are ignored
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 14'h0123; wdata = 4'h9;
    n_writes++;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0; addr = 14'h0456; wdata = 4'h1;
    begin
      int held_bad;
      held_bad = 0;
      while (!rdy) begin
        if (mem_addr != 14'h0123) held_bad++;
        @(negedge clk);
      end
      check(held_bad == 0, "R2 R3 mem_addr held while busy", held_bad, 0);
    end
    do_txn(1'b0, 14'h0123, 4'h0, got, busy, nval);
    check(got == 4'h9, "R2 write data captured at accept", int'(got), 9);
    do_txn(1'b0, 14'h0456, 4'h0, got, busy, nval);
    check(got == 4'h0, "R2 busy-time address not written", int'(got), 0);

    // R8 R6: request held high, write then read of the same word
    @(negedge clk);
    while (!rdy) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 14'h2222; wdata = 4'hE;
    n_writes++;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wdata = 4'h0;
    begin
      int k, hit;
      logic [3:0] rgot;
      k = 1; hit = 0; rgot = '0;
      while (k < 40 && hit == 0) begin
        if (k == 7) req = 1'b0;
        if (rvalid) begin
          hit = k;
          rgot = rdata;
        end else begin
          @(negedge clk);
          k++;
        end
      end
      check(hit == 11, "R8 held request taken in first idle cycle", hit, 11);
      check(rgot == 4'hE, "R6 back-to-back read data", int'(rgot), 14);
    end
    repeat (3) @(negedge clk);
    check(rdy && mem_cs_n && mem_we_n && !mem_oe && !rvalid, "R1 idle pins between transactions",
          {rdy, mem_cs_n, mem_we_n, mem_oe, rvalid}, 5'b11100);

    // model verdicts
    check(conflict == 0,  "R6 bus driven by both sides", conflict, 0);
    check(nodrive == 0,   "R6 drive outside overlap", nodrive, 0);
    check(addr_viol == 0, "R3 address moved under strobe", addr_viol, 0);
    check(lead_viol == 0, "R4 write enable did not lead", lead_viol, 0);
    check(arm_cnt == n_writes, "R4 arm cycles per write", arm_cnt, n_writes);
    check(bad_pulse == 0, "R5 overlap length", bad_pulse, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule